// File: doc/BRIEF.md
# Trap Entry and Control Register Legalization Unit

This block holds the machine-level and supervisor-level trap control registers of a RISC-V style hart. It also holds the current privilege level and the debug resume address. Every software write to these registers passes through legalization before it is stored. Privilege values are forced onto supported modes. Alignment bits are cleared on return-address and vector-base writes. Translation-control writes that name an unsupported mode are dropped. Writes through the supervisor interrupt-enable view touch only the delegated enable bits.

On a trap request the block decides where the trap goes. A breakpoint may enter debug mode. Otherwise a delegation mask picks supervisor or machine level. The block then updates the cause, return-address and value registers, and the status register's enable stack. One cycle later it presents the new program counter. Two parameters state whether user mode and supervisor mode exist, and XLEN sets the register width.

A write reaches the block through a valid/ready port. A trap request has priority over a write. While a trap is presented, `wr_ready` is low, so a write held in the same cycle waits and lands in the first cycle without a trap. Trap requests, privilege-change requests and the register read select are plain control pins.

Top module: `trapcsr_unit`

## Requirements
- R1: Privilege legalization. Encodings: user = 0, supervisor = 1, machine = 3. Without user mode, any requested level becomes 3. Otherwise a request for 2, or any request when supervisor mode is absent, becomes 0. In every other case the request is kept. The rule applies to `priv_req` and to writes of the MPP field (status bits 12:11).
- R2: Writes to the machine return address (select 1), supervisor return address (select 5) and debug return address (select 12) clear bit 0. Trap entry stores the faulting address with bit 0 cleared.
- R3: A write to the supervisor vector base (select 6) clears bits 1:0. A write to the machine vector base (select 2) clears only bit 1.
- R4: A write to the supervisor enable view (select 10) replaces only those bits of the machine enable register (select 9) that are set in `deleg_irq`. Reading select 10 returns the machine enable register ANDed with `deleg_irq`.
- R5: A write to the status register (select 0) stores only these fields: SIE bit 1, MIE bit 3, SPIE bit 5, MPIE bit 7, SPP bit 8 and MPP bits 12:11. SPP stays 0 when supervisor mode is absent.
- R6: With XLEN = 64, a write to translation control (select 11) is stored only if bits 63:60 equal 0, 8 or 9; any other value leaves the register unchanged. With XLEN = 32, every value is stored.
- R7: A non-debug trap goes to supervisor level when all of these hold: supervisor mode exists, the current level is not 3, and bit `cause` of the delegation mask is set (`deleg_irq` for interrupts, `deleg_exc` for exceptions). The trap then does the following:
  - the new PC is the supervisor vector base;
  - the supervisor cause register (select 7) gets `trap_irq` in its top bit and `cause` below it;
  - the supervisor return address gets `trap_epc`, and the supervisor value register (select 8) gets `trap_tval`;
  - SPIE takes SIE, SIE is cleared, SPP takes the old level, and the level becomes 1.
- R8: Every other non-debug trap goes to machine level, and the level becomes 3. The machine cause register (select 3) gets the cause, the return address gets `trap_epc`, and the value register (select 4) gets `trap_tval`. MPIE takes MIE, MIE is cleared, and MPP takes the old level.
- R9: The machine-level new PC is the vector base with bit 0 cleared. When vector-base bit 0 is set and the trap is an interrupt, 4 × cause is added to it. Exceptions always use offset 0.
- R10: When an exception with cause 3 arrives and the breakpoint enable for the current level (`ebrk_m`, `ebrk_s` or `ebrk_u`) is set, the trap enters debug mode. `debug_enter` pulses, the debug return address gets `trap_epc`, no PC is issued, and no trap register, status bit or level changes.
- R11: `pc_valid` and `debug_enter` are one-cycle pulses registered one cycle after the trap is accepted. `wr_ready` is low exactly while `trap_valid` is high, and a write is applied on the clock edge where `wr_valid` and `wr_ready` are both high. A `priv_req_valid` in a trap cycle is ignored.
- R12: After reset the level is 3, every register reads 0, and `pc_valid` and `debug_enter` are low. An unused select reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Register write request |
| wr_ready | output | 1 | Write accepted this cycle (low during a trap) |
| wr_sel | input | 4 | Target register select |
| wr_data | input | XLEN | Write value before legalization |
| rd_sel | input | 4 | Read select |
| rd_data | output | XLEN | Combinational read value |
| priv_req_valid | input | 1 | Request to change the privilege level |
| priv_req | input | 2 | Requested level |
| trap_valid | input | 1 | Trap request, taken in the same cycle |
| trap_irq | input | 1 | 1 = interrupt, 0 = exception |
| trap_cause | input | CAUSE_W | Cause index |
| trap_epc | input | XLEN | Address of the trapping instruction |
| trap_tval | input | XLEN | Trap value |
| deleg_irq | input | XLEN | Interrupt delegation mask, also the SIE view mask |
| deleg_exc | input | XLEN | Exception delegation mask |
| ebrk_m | input | 1 | Breakpoints at level 3 enter debug |
| ebrk_s | input | 1 | Breakpoints at level 1 enter debug |
| ebrk_u | input | 1 | Breakpoints at level 0 enter debug |
| cur_priv | output | 2 | Current privilege level |
| pc_valid | output | 1 | New PC pulse |
| pc_addr | output | XLEN | New PC |
| debug_enter | output | 1 | Debug entry pulse |

## Verification
The bench builds two instances that share every input. The first uses XLEN = 64 with user and supervisor modes. It reaches the translation-mode filter, supervisor delegation, the SPP path and the reserved-level rule. The second uses XLEN = 32 with neither mode. It shows requests and MPP collapsing to machine level, SPP staying 0, every translation mode being accepted, and every trap landing at machine level even when delegation bits are set.

// File: rtl/trapcsr_pkg.sv
package trapcsr_pkg;

  // Privilege level encodings.
  localparam logic [1:0] PRIV_U   = 2'd0;
  localparam logic [1:0] PRIV_S   = 2'd1;
  localparam logic [1:0] PRIV_RSV = 2'd2;
  localparam logic [1:0] PRIV_M   = 2'd3;

  // Register selects.
  typedef enum logic [3:0] {
    SEL_MSTATUS = 4'd0,
    SEL_MEPC    = 4'd1,
    SEL_MTVEC   = 4'd2,
    SEL_MCAUSE  = 4'd3,
    SEL_MTVAL   = 4'd4,
    SEL_SEPC    = 4'd5,
    SEL_STVEC   = 4'd6,
    SEL_SCAUSE  = 4'd7,
    SEL_STVAL   = 4'd8,
    SEL_MIE     = 4'd9,
    SEL_SIE     = 4'd10,
    SEL_SATP    = 4'd11,
    SEL_DPC     = 4'd12
  } csr_sel_e;

  // Status register bit positions.
  localparam int unsigned ST_SIE  = 1;
  localparam int unsigned ST_MIE  = 3;
  localparam int unsigned ST_SPIE = 5;
  localparam int unsigned ST_MPIE = 7;
  localparam int unsigned ST_SPP  = 8;
  localparam int unsigned ST_MPP  = 11;

  localparam int unsigned BRK_CAUSE = 3;

  // Force a requested level onto a supported one.
  function automatic logic [1:0] legal_priv(input logic [1:0] req,
                                            input logic has_u,
                                            input logic has_s);
    if (!has_u)
      return PRIV_M;
    if (req == PRIV_RSV || !has_s)
      return PRIV_U;
    return req;
  endfunction

endpackage

// File: rtl/trapcsr_wr_legal.sv
module trapcsr_wr_legal
  import trapcsr_pkg::*;
#(
  parameter int unsigned XLEN  = 64,
  parameter bit          HAS_U = 1'b1,
  parameter bit          HAS_S = 1'b1
) (
  input  logic [XLEN-1:0] data,
  input  logic [XLEN-1:0] mstatus_cur,
  input  logic [XLEN-1:0] mie_cur,
  input  logic [XLEN-1:0] satp_cur,
  input  logic [XLEN-1:0] sie_mask,
  output logic [XLEN-1:0] mstatus_nxt,
  output logic [XLEN-1:0] mie_via_sie,
  output logic [XLEN-1:0] satp_nxt,
  output logic [XLEN-1:0] addr_even,
  output logic [XLEN-1:0] stvec_nxt,
  output logic [XLEN-1:0] mtvec_nxt
);

  localparam logic [XLEN-1:0] ENA_MASK =
      (XLEN'(1) << ST_SIE) | (XLEN'(1) << ST_MIE) |
      (XLEN'(1) << ST_SPIE) | (XLEN'(1) << ST_MPIE) |
      (HAS_S ? (XLEN'(1) << ST_SPP) : '0);

  logic [1:0] mpp_legal;

  always_comb begin
    mpp_legal   = legal_priv(data[ST_MPP +: 2], HAS_U, HAS_S);
    mstatus_nxt = (data & ENA_MASK) | (XLEN'(mpp_legal) << ST_MPP);
    mie_via_sie = (mie_cur & ~sie_mask) | (data & sie_mask);
    addr_even   = {data[XLEN-1:1], 1'b0};
    stvec_nxt   = {data[XLEN-1:2], 2'b00};
    mtvec_nxt   = data & ~(XLEN'(2));
  end

  generate
    if (XLEN == 64) begin : g_satp64
      logic [3:0] mode;
      always_comb begin
        mode     = data[63:60];
        satp_nxt = (mode == 4'd0 || mode == 4'd8 || mode == 4'd9) ? data : satp_cur;
      end
    end else begin : g_satp32
      assign satp_nxt = data;
    end
  endgenerate

  // The unused upper status bits never carry state.
  logic unused_ok;
  assign unused_ok = ^mstatus_cur;

endmodule

// File: rtl/trapcsr_route.sv
module trapcsr_route
  import trapcsr_pkg::*;
#(
  parameter int unsigned XLEN    = 64,
  parameter int unsigned CAUSE_W = 6,
  parameter bit          HAS_S   = 1'b1
) (
  input  logic               irq,
  input  logic [CAUSE_W-1:0] cause,
  input  logic [1:0]         priv,
  input  logic [XLEN-1:0]    deleg_irq,
  input  logic [XLEN-1:0]    deleg_exc,
  input  logic [XLEN-1:0]    stvec,
  input  logic [XLEN-1:0]    mtvec,
  input  logic               ebrk_m,
  input  logic               ebrk_s,
  input  logic               ebrk_u,
  output logic               to_super,
  output logic               to_debug,
  output logic [XLEN-1:0]    new_pc
);

  logic [XLEN-1:0] shifted;
  logic            brk_en;
  logic [XLEN-1:0] vec_off;

  always_comb begin
    shifted = (irq ? deleg_irq : deleg_exc) >> cause;
    to_super = HAS_S && (priv != PRIV_M) && shifted[0];

    unique case (priv)
      PRIV_M:  brk_en = ebrk_m;
      PRIV_S:  brk_en = ebrk_s;
      PRIV_U:  brk_en = ebrk_u;
      default: brk_en = 1'b0;
    endcase
    to_debug = !irq && (cause == CAUSE_W'(BRK_CAUSE)) && brk_en;

    vec_off = (mtvec[0] && irq) ? (XLEN'(cause) << 2) : '0;
    new_pc  = to_super ? stvec : ({mtvec[XLEN-1:1], 1'b0} + vec_off);
  end

endmodule

// File: rtl/trapcsr_unit.sv
module trapcsr_unit
  import trapcsr_pkg::*;
#(
  parameter int unsigned XLEN    = 64,
  parameter int unsigned CAUSE_W = 6,
  parameter bit          HAS_U   = 1'b1,
  parameter bit          HAS_S   = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_valid,
  output logic               wr_ready,
  input  logic [3:0]         wr_sel,
  input  logic [XLEN-1:0]    wr_data,
  input  logic [3:0]         rd_sel,
  output logic [XLEN-1:0]    rd_data,
  input  logic               priv_req_valid,
  input  logic [1:0]         priv_req,
  input  logic               trap_valid,
  input  logic               trap_irq,
  input  logic [CAUSE_W-1:0] trap_cause,
  input  logic [XLEN-1:0]    trap_epc,
  input  logic [XLEN-1:0]    trap_tval,
  input  logic [XLEN-1:0]    deleg_irq,
  input  logic [XLEN-1:0]    deleg_exc,
  input  logic               ebrk_m,
  input  logic               ebrk_s,
  input  logic               ebrk_u,
  output logic [1:0]         cur_priv,
  output logic               pc_valid,
  output logic [XLEN-1:0]    pc_addr,
  output logic               debug_enter
);

  localparam int unsigned PAD_W = XLEN - 1 - CAUSE_W;

  logic [1:0]      priv_q;
  logic [XLEN-1:0] mstatus_q, mepc_q, mtvec_q, mcause_q, mtval_q;
  logic [XLEN-1:0] sepc_q, stvec_q, scause_q, stval_q;
  logic [XLEN-1:0] mie_q, satp_q, dpc_q;
  logic            pc_valid_q, dbg_q;
  logic [XLEN-1:0] pc_q;

  logic [XLEN-1:0] mstatus_w, mie_sie_w, satp_w, addr_even_w, stvec_w, mtvec_w;
  logic            to_super, to_debug;
  logic [XLEN-1:0] route_pc;
  logic [XLEN-1:0] cause_full;
  logic [XLEN-1:0] epc_even;

  assign wr_ready   = !trap_valid;
  assign cause_full = {trap_irq, {PAD_W{1'b0}}, trap_cause};
  assign epc_even   = {trap_epc[XLEN-1:1], 1'b0};

  trapcsr_wr_legal #(.XLEN(XLEN), .HAS_U(HAS_U), .HAS_S(HAS_S)) u_legal (
    .data        (wr_data),
    .mstatus_cur (mstatus_q),
    .mie_cur     (mie_q),
    .satp_cur    (satp_q),
    .sie_mask    (deleg_irq),
    .mstatus_nxt (mstatus_w),
    .mie_via_sie (mie_sie_w),
    .satp_nxt    (satp_w),
    .addr_even   (addr_even_w),
    .stvec_nxt   (stvec_w),
    .mtvec_nxt   (mtvec_w)
  );

  trapcsr_route #(.XLEN(XLEN), .CAUSE_W(CAUSE_W), .HAS_S(HAS_S)) u_route (
    .irq       (trap_irq),
    .cause     (trap_cause),
    .priv      (priv_q),
    .deleg_irq (deleg_irq),
    .deleg_exc (deleg_exc),
    .stvec     (stvec_q),
    .mtvec     (mtvec_q),
    .ebrk_m    (ebrk_m),
    .ebrk_s    (ebrk_s),
    .ebrk_u    (ebrk_u),
    .to_super  (to_super),
    .to_debug  (to_debug),
    .new_pc    (route_pc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      priv_q     <= PRIV_M;
      mstatus_q  <= '0;
      mepc_q     <= '0;
      mtvec_q    <= '0;
      mcause_q   <= '0;
      mtval_q    <= '0;
      sepc_q     <= '0;
      stvec_q    <= '0;
      scause_q   <= '0;
      stval_q    <= '0;
      mie_q      <= '0;
      satp_q     <= '0;
      dpc_q      <= '0;
      pc_valid_q <= 1'b0;
      dbg_q      <= 1'b0;
      pc_q       <= '0;
    end else if (trap_valid) begin
      pc_valid_q <= !to_debug;
      dbg_q      <= to_debug;
      if (to_debug) begin
        dpc_q <= epc_even;
      end else if (to_super) begin
        pc_q               <= route_pc;
        scause_q           <= cause_full;
        sepc_q             <= epc_even;
        stval_q            <= trap_tval;
        mstatus_q[ST_SPIE] <= mstatus_q[ST_SIE];
        mstatus_q[ST_SIE]  <= 1'b0;
        mstatus_q[ST_SPP]  <= priv_q[0];
        priv_q             <= PRIV_S;
      end else begin
        pc_q                   <= route_pc;
        mcause_q               <= cause_full;
        mepc_q                 <= epc_even;
        mtval_q                <= trap_tval;
        mstatus_q[ST_MPIE]     <= mstatus_q[ST_MIE];
        mstatus_q[ST_MIE]      <= 1'b0;
        mstatus_q[ST_MPP +: 2] <= priv_q;
        priv_q                 <= PRIV_M;
      end
    end else begin
      pc_valid_q <= 1'b0;
      dbg_q      <= 1'b0;
      if (wr_valid) begin
        unique case (wr_sel)
          SEL_MSTATUS: mstatus_q <= mstatus_w;
          SEL_MEPC:    mepc_q    <= addr_even_w;
          SEL_MTVEC:   mtvec_q   <= mtvec_w;
          SEL_MCAUSE:  mcause_q  <= wr_data;
          SEL_MTVAL:   mtval_q   <= wr_data;
          SEL_SEPC:    sepc_q    <= addr_even_w;
          SEL_STVEC:   stvec_q   <= stvec_w;
          SEL_SCAUSE:  scause_q  <= wr_data;
          SEL_STVAL:   stval_q   <= wr_data;
          SEL_MIE:     mie_q     <= wr_data;
          SEL_SIE:     mie_q     <= mie_sie_w;
          SEL_SATP:    satp_q    <= satp_w;
          SEL_DPC:     dpc_q     <= addr_even_w;
          default: ;
        endcase
      end
      if (priv_req_valid)
        priv_q <= legal_priv(priv_req, HAS_U, HAS_S);
    end
  end

  always_comb begin
    unique case (rd_sel)
      SEL_MSTATUS: rd_data = mstatus_q;
      SEL_MEPC:    rd_data = mepc_q;
      SEL_MTVEC:   rd_data = mtvec_q;
      SEL_MCAUSE:  rd_data = mcause_q;
      SEL_MTVAL:   rd_data = mtval_q;
      SEL_SEPC:    rd_data = sepc_q;
      SEL_STVEC:   rd_data = stvec_q;
      SEL_SCAUSE:  rd_data = scause_q;
      SEL_STVAL:   rd_data = stval_q;
      SEL_MIE:     rd_data = mie_q;
      SEL_SIE:     rd_data = mie_q & deleg_irq;
      SEL_SATP:    rd_data = satp_q;
      SEL_DPC:     rd_data = dpc_q;
      default:     rd_data = '0;
    endcase
  end

  assign cur_priv    = priv_q;
  assign pc_valid    = pc_valid_q;
  assign pc_addr     = pc_q;
  assign debug_enter = dbg_q;

  // Stored level is always a supported one.
  p_priv_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    priv_q != PRIV_RSV && (HAS_S || priv_q != PRIV_S) && (HAS_U || priv_q == PRIV_M));

  p_ret_even_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mepc_q[0] && !sepc_q[0] && !dpc_q[0]);

  p_vec_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stvec_q[1:0] == 2'b00 && !mtvec_q[1]);

  p_sie_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_valid_q && priv_q == PRIV_S) |-> !mstatus_q[ST_SIE]);

  p_mie_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_valid_q && priv_q == PRIV_M) |-> !mstatus_q[ST_MIE]);

  p_dbg_keeps_priv_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && to_debug) |=> (debug_enter && !pc_valid && $stable(priv_q)));

  p_trap_answer_r11: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |=> (pc_valid_q != dbg_q));

  p_wr_blocked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> !wr_ready);

endmodule

// File: tb/trapcsr_unit_tb.sv
`timescale 1ns/1ps
module trapcsr_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [3:0]  wr_sel = '0;
  logic [63:0] wr_data = '0;
  logic [3:0]  rd_sel = '0;
  logic        priv_req_valid = 1'b0;
  logic [1:0]  priv_req = '0;
  logic        trap_valid = 1'b0;
  logic        trap_irq = 1'b0;
  logic [5:0]  trap_cause = '0;
  logic [63:0] trap_epc = '0;
  logic [63:0] trap_tval = '0;
  logic [63:0] deleg_irq = '0;
  logic [63:0] deleg_exc = '0;
  logic        ebrk_m = 1'b0, ebrk_s = 1'b0, ebrk_u = 1'b0;

  logic        a_wr_ready, a_pc_valid, a_dbg;
  logic [63:0] a_rd, a_pc;
  logic [1:0]  a_priv;
  logic        b_wr_ready, b_pc_valid, b_dbg;
  logic [31:0] b_rd, b_pc;
  logic [1:0]  b_priv;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  trapcsr_unit #(.XLEN(64), .CAUSE_W(6), .HAS_U(1'b1), .HAS_S(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(a_wr_ready),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(a_rd),
    .priv_req_valid(priv_req_valid), .priv_req(priv_req),
    .trap_valid(trap_valid), .trap_irq(trap_irq), .trap_cause(trap_cause),
    .trap_epc(trap_epc), .trap_tval(trap_tval), .deleg_irq(deleg_irq),
    .deleg_exc(deleg_exc), .ebrk_m(ebrk_m), .ebrk_s(ebrk_s), .ebrk_u(ebrk_u),
    .cur_priv(a_priv), .pc_valid(a_pc_valid), .pc_addr(a_pc), .debug_enter(a_dbg)
  );

  trapcsr_unit #(.XLEN(32), .CAUSE_W(6), .HAS_U(1'b0), .HAS_S(1'b0)) u_dut_mo (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(b_wr_ready),
    .wr_sel(wr_sel), .wr_data(wr_data[31:0]), .rd_sel(rd_sel), .rd_data(b_rd),
    .priv_req_valid(priv_req_valid), .priv_req(priv_req),
    .trap_valid(trap_valid), .trap_irq(trap_irq), .trap_cause(trap_cause),
    .trap_epc(trap_epc[31:0]), .trap_tval(trap_tval[31:0]), .deleg_irq(deleg_irq[31:0]),
    .deleg_exc(deleg_exc[31:0]), .ebrk_m(ebrk_m), .ebrk_s(ebrk_s), .ebrk_u(ebrk_u),
    .cur_priv(b_priv), .pc_valid(b_pc_valid), .pc_addr(b_pc), .debug_enter(b_dbg)
  );

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] sel, input logic [63:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic set_priv(input logic [1:0] p);
    @(negedge clk);
    priv_req_valid = 1'b1; priv_req = p;
    @(posedge clk);
    @(negedge clk);
    priv_req_valid = 1'b0;
  endtask

  task automatic trap(input logic irq, input logic [5:0] c,
                      input logic [63:0] epc, input logic [63:0] tval);
    @(negedge clk);
    trap_valid = 1'b1; trap_irq = irq; trap_cause = c; trap_epc = epc; trap_tval = tval;
    @(posedge clk);
    @(negedge clk);
    trap_valid = 1'b0;
  endtask

  task automatic rd_a(input logic [3:0] sel, input logic [63:0] exp, input string what);
    rd_sel = sel; #0.2;
    chk(a_rd, exp, what);
  endtask

  task automatic rd_b(input logic [3:0] sel, input logic [31:0] exp, input string what);
    rd_sel = sel; #0.2;
    chk({32'd0, b_rd}, {32'd0, exp}, what);
  endtask

  task automatic t_reset;
    chk({62'd0, a_priv}, 64'd3, "R12 reset level");
    chk({63'd0, a_pc_valid}, 64'd0, "R12 reset pc_valid");
    chk({63'd0, a_dbg}, 64'd0, "R12 reset debug_enter");
    rd_a(4'd0, 64'd0, "R12 reset status");
    rd_a(4'd2, 64'd0, "R12 reset mtvec");
    rd_a(4'd15, 64'd0, "R12 unused select");
    rd_b(4'd0, 32'd0, "R12 reset status (mo)");
  endtask

  task automatic t_priv;
    set_priv(2'd2);
    chk({62'd0, a_priv}, 64'd0, "R1 reserved request -> U");
    chk({62'd0, b_priv}, 64'd3, "R1 no-U request -> M");
    set_priv(2'd1);
    chk({62'd0, a_priv}, 64'd1, "R1 S request kept");
    set_priv(2'd0);
    chk({62'd0, b_priv}, 64'd3, "R1 no-U U request -> M");
    set_priv(2'd3);
    chk({62'd0, a_priv}, 64'd3, "R1 M request kept");
    wr(4'd0, 64'h1000);
    rd_a(4'd0, 64'h0, "R1 MPP=2 -> U");
    wr(4'd0, 64'h0800);
    rd_a(4'd0, 64'h0800, "R1 MPP=1 kept");
    rd_b(4'd0, 32'h1800, "R1 MPP=1 -> M (mo)");
  endtask

  task automatic t_align;
    wr(4'd1, 64'h1235);  rd_a(4'd1, 64'h1234, "R2 mepc bit0");
    wr(4'd5, 64'hFFF);   rd_a(4'd5, 64'hFFE, "R2 sepc bit0");
    wr(4'd12, 64'h7);    rd_a(4'd12, 64'h6, "R2 dpc bit0");
    wr(4'd6, 64'h203);   rd_a(4'd6, 64'h200, "R3 stvec low bits");
    wr(4'd2, 64'h107);   rd_a(4'd2, 64'h105, "R3 mtvec bit1 only");
  endtask

  task automatic t_sie;
    deleg_irq = 64'h222;
    wr(4'd9, 64'hAAA);
    wr(4'd10, 64'h0);
    rd_a(4'd9, 64'h888, "R4 SIE write clears only delegated bits");
    wr(4'd10, 64'hFFF);
    rd_a(4'd9, 64'hAAA, "R4 SIE write sets only delegated bits");
    rd_a(4'd10, 64'h222, "R4 SIE read view");
  endtask

  task automatic t_status;
    wr(4'd0, 64'hFFFF);
    rd_a(4'd0, 64'h19AA, "R5 status field mask");
    rd_b(4'd0, 32'h18AA, "R5 SPP fixed without S (mo)");
    wr(4'd0, 64'h0);
    rd_a(4'd0, 64'h0, "R5 status cleared");
    rd_b(4'd0, 32'h1800, "R5 MPP stays M (mo)");
  endtask

  task automatic t_satp;
    wr(4'd11, 64'h8000_0000_0000_1234);
    rd_a(4'd11, 64'h8000_0000_0000_1234, "R6 mode 8 accepted");
    wr(4'd11, 64'h1000_0000_0000_0055);
    rd_a(4'd11, 64'h8000_0000_0000_1234, "R6 mode 1 dropped");
    rd_b(4'd11, 32'h55, "R6 XLEN32 accepts all");
    wr(4'd11, 64'h9000_0000_0000_0ABC);
    rd_a(4'd11, 64'h9000_0000_0000_0ABC, "R6 mode 9 accepted");
  endtask

  task automatic t_trap_super;
    set_priv(2'd1);
    wr(4'd6, 64'h4000);
    wr(4'd0, 64'h2);
    deleg_exc = 64'h100;
    trap(1'b0, 6'd8, 64'h1001, 64'hBEEF);
    chk({63'd0, a_pc_valid}, 64'd1, "R7 pc_valid pulse");
    chk(a_pc, 64'h4000, "R7 pc from stvec");
    chk({62'd0, a_priv}, 64'd1, "R7 level S");
    chk({62'd0, b_priv}, 64'd3, "R7 no-S routes to M (mo)");
    chk({32'd0, b_pc}, 64'h104, "R9 mo exception no offset");
    rd_a(4'd7, 64'd8, "R7 scause");
    rd_a(4'd5, 64'h1000, "R7 sepc");
    rd_a(4'd8, 64'hBEEF, "R7 stval");
    rd_a(4'd0, 64'h120, "R7 SPIE/SIE/SPP");
  endtask

  task automatic t_trap_machine;
    wr(4'd2, 64'h2001);
    wr(4'd0, 64'h8);
    trap(1'b1, 6'd7, 64'h3000, 64'h0);
    chk(a_pc, 64'h201C, "R9 vectored irq offset");
    chk({32'd0, b_pc}, 64'h201C, "R9 vectored irq offset (mo)");
    chk({62'd0, a_priv}, 64'd3, "R8 level M");
    rd_a(4'd3, 64'h8000_0000_0000_0007, "R8 mcause irq bit");
    rd_a(4'd1, 64'h3000, "R8 mepc");
    rd_a(4'd0, 64'h880, "R8 MPIE/MIE/MPP");
    trap(1'b0, 6'd2, 64'h3100, 64'h44);
    chk(a_pc, 64'h2000, "R9 vectored exception offset zero");
    rd_a(4'd0, 64'h1800, "R8 MPP from M");
    rd_a(4'd4, 64'h44, "R8 mtval");
  endtask

  task automatic t_debug;
    ebrk_m = 1'b1;
    trap(1'b0, 6'd3, 64'h5003, 64'h0);
    chk({63'd0, a_dbg}, 64'd1, "R10 debug_enter");
    chk({63'd0, a_pc_valid}, 64'd0, "R10 no pc");
    rd_a(4'd12, 64'h5002, "R10 dpc");
    rd_a(4'd1, 64'h3100, "R10 mepc untouched");
    rd_a(4'd0, 64'h1800, "R10 status untouched");
    ebrk_m = 1'b0;
    trap(1'b0, 6'd3, 64'h6000, 64'h0);
    chk({63'd0, a_pc_valid}, 64'd1, "R10 disabled breakpoint traps");
    rd_a(4'd3, 64'd3, "R10 mcause breakpoint");
  endtask

  task automatic t_handshake;
    @(negedge clk);
    chk({63'd0, a_wr_ready}, 64'd1, "R11 ready idle");
    wr_valid = 1'b1; wr_sel = 4'd4; wr_data = 64'h77;
    trap_valid = 1'b1; trap_irq = 1'b0; trap_cause = 6'd2;
    trap_epc = 64'h7000; trap_tval = 64'h99;
    priv_req_valid = 1'b1; priv_req = 2'd0;
    #0.2;
    chk({63'd0, a_wr_ready}, 64'd0, "R11 ready low during trap");
    @(posedge clk);
    @(negedge clk);
    trap_valid = 1'b0; priv_req_valid = 1'b0;
    rd_a(4'd4, 64'h99, "R11 trap wins over write");
    chk({62'd0, a_priv}, 64'd3, "R11 priv request ignored in trap cycle");
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
    chk({63'd0, a_pc_valid}, 64'd0, "R11 pc_valid is one cycle");
    rd_a(4'd4, 64'h77, "R11 held write lands after trap");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_priv();
    t_align();
    t_sie();
    t_status();
    t_satp();
    t_trap_super();
    t_trap_machine();
    t_debug();
    t_handshake();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule